// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block accepts raw keyboard scan code bytes, one per strobe, and turns each complete code into a key event. An event holds a 7-bit key index, a flag that separates a key release from a key press, and a flag that marks a code announced by the two-byte extended prefix. A prefix byte on its own produces no event. It only arms the extended flag for the next ordinary byte.

Each event leaves the block in two ways. It appears as a one-cycle pulse on a dedicated output. It is also offered to a one-entry holding register that host software reaches through a small port-style register interface. That interface has two addresses. The data address reads or writes the holding register. The control address returns status on a read and accepts a command on a write. Reading the data address consumes the held event. An event that arrives while the previous one is still unread is dropped, and a sticky error bit records the loss.

Top module: `kbd_event_decoder`

## Requirements
- R1: After reset the status word reads 0, the event pulse is low and no prefix is pending.
- R2: For every non-prefix byte, one cycle after its strobe `evt_valid` pulses for one cycle. `evt_code[6:0]` carries byte bits 6:0 as the key index. `evt_code[7]` carries byte bit 7, which is 1 for a release and 0 for a press, so 0x1E gives a press and 0x9E gives a release of the same key.
- R3: The byte 0xE0 produces no event and sets the pending prefix. A repeated 0xE0 keeps the prefix pending. The next non-prefix byte's event has `evt_code[8]` = 1.
- R4: The extended flag applies to exactly one event. The byte after an extended event decodes with `evt_code[8]` = 0 unless a new prefix arrives first.
- R5: An accepted event is written to the data register one cycle after its pulse and sets status bit 0 (data available). A read at the data address (0x60) returns the event in bits 8:0, with the upper bits zero.
- R6: A read at the data address clears status bit 0. A read at the control address (0x64) has no side effect.
- R7: If an event completes while status bit 0 is set, the data register keeps its old value and the new event is dropped. Status bit 1 (overrun) is then set and stays set until a flush.
- R8: Writing 0xFF to the control address clears the pending prefix, the overrun bit and the data-available bit in one cycle. Any other command value has no effect.
- R9: Status bit 2 reads 1 exactly while a prefix is pending.
- R10: A host write to the data address loads `bus_wdata[8:0]` into the data register and sets status bit 0.
- R11: A read at any address other than 0x60 or 0x64 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | Scan code byte strobe |
| code_byte | input | 8 | Scan code byte |
| bus_rd | input | 1 | Register read strobe; the read side effect applies at the clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register port address |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Combinational read data for `bus_addr` |
| evt_valid | output | 1 | One-cycle event pulse |
| evt_code | output | 9 | Event: bit 8 extended, bit 7 release, bits 6:0 key index |

## Verification
The bench targets four areas of the prefix handling:
- A doubled 0xE0. A design that counted prefixes would emit a spurious event or lose the extended flag.
- The byte right after an extended code. A design that failed to clear the flag would mark it extended as well.
- An overrun. A design that overwrote the data register or cleared the overrun bit on a read would return the newer key and hide the loss.
- Flushes and non-flush commands. The bench issues a flush while a prefix is pending, and a command value other than 0xFF. A design that decoded commands loosely, or did not clear the prefix on a flush, would either wipe status by accident or tag the next key as extended.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;
  localparam int CODE_W = 8;
  localparam int KEY_W  = 7;
  localparam int EVT_W  = KEY_W + 2;
  localparam logic [CODE_W-1:0] PREFIX_CODE = 8'hE0;
  localparam logic [CODE_W-1:0] FLUSH_CMD   = 8'hFF;

  // bit 8 = extended, bit 7 = release, bits 6:0 = key index
  typedef struct packed {
    logic             ext;
    logic             rel;
    logic [KEY_W-1:0] key;
  } key_evt_t;

  function automatic logic is_prefix(input logic [CODE_W-1:0] b);
    return b == PREFIX_CODE;
  endfunction

  function automatic key_evt_t decode_code(input logic [CODE_W-1:0] b,
                                           input logic ext);
    key_evt_t e;
    e.ext = ext;
    e.rel = b[CODE_W-1];
    e.key = b[KEY_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/kbd_prefix_tracker.sv
module kbd_prefix_tracker
  import kbd_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_byte,
  input  logic              flush,
  output logic              evt_valid,
  output key_evt_t          evt,
  output logic              prefix_pend
);
  logic byte_is_prefix;
  assign byte_is_prefix = is_prefix(code_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid   <= 1'b0;
      evt         <= '0;
      prefix_pend <= 1'b0;
    end else if (flush) begin
      evt_valid   <= 1'b0;
      prefix_pend <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      if (code_valid) begin
        if (byte_is_prefix) begin
          prefix_pend <= 1'b1;
        end else begin
          evt_valid   <= 1'b1;
          evt         <= decode_code(code_byte, prefix_pend);
          prefix_pend <= 1'b0;
        end
      end
    end
  end

  p_prefix_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && byte_is_prefix && !flush |=> !evt_valid && prefix_pend);
  p_ext_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !prefix_pend);
  p_pulse_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(code_valid) && evt.rel == $past(code_byte[CODE_W-1]));
endmodule

// File: rtl/kbd_port_decode.sv
module kbd_port_decode
  import kbd_evt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                BUS_W     = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h64
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [EVT_W-1:0]  data_q,
  input  logic [2:0]        status_bits,
  output logic              data_rd,
  output logic              data_wr,
  output logic              cmd_flush,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam logic [BUS_W-1:0] FLUSH_WORD = {{(BUS_W-CODE_W){1'b0}}, FLUSH_CMD};

  logic hit_data, hit_ctrl;
  assign hit_data  = bus_addr == DATA_ADDR;
  assign hit_ctrl  = bus_addr == CTRL_ADDR;
  assign data_rd   = bus_rd && hit_data;
  assign data_wr   = bus_wr && hit_data;
  assign cmd_flush = bus_wr && hit_ctrl && (bus_wdata == FLUSH_WORD);

  always_comb begin
    bus_rdata = '0;
    if (hit_data)      bus_rdata = {{(BUS_W-EVT_W){1'b0}}, data_q};
    else if (hit_ctrl) bus_rdata = {{(BUS_W-3){1'b0}}, status_bits};
  end
endmodule

// File: rtl/kbd_out_holder.sv
module kbd_out_holder
  import kbd_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  key_evt_t         evt,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic [EVT_W-1:0] wdata,
  input  logic             flush,
  output logic [EVT_W-1:0] data_q,
  output logic             avail,
  output logic             overrun
);
  logic slot_free, accept_evt, drop_evt;
  assign slot_free  = !avail || data_rd;
  assign accept_evt = evt_valid && slot_free && !data_wr && !flush;
  assign drop_evt   = evt_valid && !slot_free && !data_wr && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      avail   <= 1'b0;
      overrun <= 1'b0;
    end else if (flush) begin
      avail   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (data_wr) begin
        data_q <= wdata;
        avail  <= 1'b1;
      end else if (accept_evt) begin
        data_q <= evt;
        avail  <= 1'b1;
      end else if (data_rd) begin
        avail  <= 1'b0;
      end
      if (drop_evt) overrun <= 1'b1;
    end
  end

  p_load_sets_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> avail && data_q == $past(evt));
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !evt_valid && !data_wr && !flush |=> !avail);
  p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun && $stable(data_q));
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !flush |=> overrun);
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !avail && !overrun);
  p_host_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !flush |=> avail && data_q == $past(wdata));
endmodule

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder
  import kbd_evt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                BUS_W     = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [7:0]        code_byte,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              evt_valid,
  output logic [8:0]        evt_code
);
  logic             flush, data_rd, data_wr, prefix_pend, avail, overrun;
  key_evt_t         evt;
  logic [EVT_W-1:0] data_q;
  logic [2:0]       status_bits;

  assign status_bits = {prefix_pend, overrun, avail};
  assign evt_code    = evt;

  kbd_prefix_tracker u_track (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
    .flush(flush), .evt_valid(evt_valid), .evt(evt), .prefix_pend(prefix_pend)
  );

  kbd_port_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .data_q(data_q), .status_bits(status_bits), .data_rd(data_rd),
    .data_wr(data_wr), .cmd_flush(flush), .bus_rdata(bus_rdata)
  );

  kbd_out_holder u_hold (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt(evt),
    .data_rd(data_rd), .data_wr(data_wr), .wdata(bus_wdata[EVT_W-1:0]),
    .flush(flush), .data_q(data_q), .avail(avail), .overrun(overrun)
  );

  p_status_prefix_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && !flush && code_byte == PREFIX_CODE |=> bus_rd || status_bits[2]);
  p_flush_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !prefix_pend && !evt_valid);
endmodule

// File: tb/kbd_event_decoder_tb.sv
module kbd_event_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        code_valid = 1'b0;
  logic [7:0]  code_byte = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        evt_valid;
  logic [8:0]  evt_code;

  int checks = 0, fails = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  kbd_event_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_valid(evt_valid), .evt_code(evt_code)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: push the expected event, then strobe the byte; returns once the data register could be loaded
  task automatic send(input logic [7:0] b, input string tag);
    if (b != 8'hE0) begin
      exp_q.push_back({pend, b});
      tag_q.push_back(tag);
      pend = 1'b0;
    end else pend = 1'b1;
    @(negedge clk); code_valid = 1'b1; code_byte = b;
    @(negedge clk); code_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // Monitor: compare each event pulse with the scoreboard
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3: unexpected event actual %h expected none", evt_code);
      end else begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {7'b0, evt_code}, {7'b0, e});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check("R1 evt_valid", {15'b0, evt_valid}, 16'h0);
    rst_n = 1'b1;
    rd(8'h64, d); check("R1 status", d, 16'h0);

    send(8'h1E, "R2 press");
    rd(8'h64, d); check("R5 status avail", d, 16'h1);
    rd(8'h64, d); check("R6 status read no side effect", d, 16'h1);
    rd(8'h60, d); check("R5 data", d, 16'h01E);
    rd(8'h64, d); check("R6 avail cleared", d, 16'h0);

    send(8'h9E, "R2 release");
    rd(8'h60, d); check("R2 data release", d, 16'h09E);

    send(8'hE0, "");
    rd(8'h64, d); check("R9 prefix pending", d, 16'h4);
    send(8'h30, "R3 extended");
    rd(8'h64, d); check("R9 prefix cleared", d, 16'h1);
    rd(8'h60, d); check("R3 data ext", d, 16'h130);
    send(8'h30, "R4 ext cleared");
    rd(8'h60, d); check("R4 data", d, 16'h030);

    send(8'hE0, ""); send(8'hE0, "");
    send(8'h2E, "R3 double prefix");
    rd(8'h60, d); check("R3 double prefix data", d, 16'h12E);

    send(8'h10, "R2 first");
    send(8'h11, "R7 dropped pulse");
    rd(8'h64, d); check("R7 overrun status", d, 16'h3);
    rd(8'h60, d); check("R7 old data kept", d, 16'h010);
    rd(8'h64, d); check("R7 overrun sticky", d, 16'h2);

    wr(8'h64, 16'h0012);
    rd(8'h64, d); check("R8 other command ignored", d, 16'h2);
    send(8'hE0, "");
    wr(8'h64, 16'h00FF); pend = 1'b0;
    rd(8'h64, d); check("R8 flush status", d, 16'h0);
    send(8'h20, "R8 no ext after flush");
    rd(8'h60, d); check("R8 data", d, 16'h020);

    wr(8'h60, 16'h01AB);
    rd(8'h64, d); check("R10 avail", d, 16'h1);
    rd(8'h60, d); check("R10 data", d, 16'h1AB);

    rd(8'h50, d); check("R11 unmapped", d, 16'h0);

    repeat (4) @(negedge clk);
    check("R2 all events seen", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule